// File: doc/BRIEF.md
# Chip-Selected Two-Wire Configuration Register Slave

This block is the configuration front end of a four-channel line conditioner. A host reaches it over an SMBus-style two-wire port. The block shifts bits on the clock line and watches the data line for START, repeated START and STOP. It accepts one fixed 7-bit device address. For a write it takes a register pointer and one data byte. For a read, the host sends the pointer, issues a repeated START, and the block shifts one byte back. A separate select input must be high before any of this happens, so several identical slaves can share the same two wires.

Behind the port is a byte-wide register bank:

- Writable registers hold, for each channel, a disable flag and a 3-bit boost code. They also hold the ON and OFF detect-threshold codes, an enable-source select and an output-level code.
- Read-only registers report live state: the per-channel detect flags, and the enable and boost values each channel actually uses.

The effective enable comes either from a per-channel pin or from the register disable flag. The effective boost comes either from a shared pin code or from the per-channel register code.

Both bus lines pass through a synchronizer and a glitch filter before any edge is decoded. The block drives the data line only through an open-drain pull-down enable.

Top module: `cfg_twowire_regbank`

## Requirements
- R1: Only the address 1010110 (byte 0xAC for write, 0xAD for read) is acknowledged; any other address byte gets no ACK, and the rest of that transaction is ignored.
- R2: While `sel` is low, `sda_pull` stays low and no bus traffic changes any register.
- R3: A write consists of address+W, pointer and data. The slave acknowledges each byte by pulling SDA low in the ninth clock, and the data lands in the addressed register.
- R4: A read consists of address+W and pointer, then a repeated START, then address+R with an ACK. The slave then drives the 8 bits of the addressed register, MSB first.
- R5: After reset, registers 0x03 and 0x04 read 0x44, 0x05, 0x06 and 0x07 read 0x00, and 0x08 reads 0x78.
- R6: Writes to the read-only addresses 0x00–0x02 and to unmapped addresses (above 0x08) are acknowledged and discarded. A read of an unmapped address returns 0x00.
- R7: Register 0x00 carries detect flag n in bit n, bits 7:4 zero. Register 0x01 carries channel 0 in bits 3:0 and channel 1 in bits 7:4; register 0x02 does the same for channels 2 and 3. In each nibble, bit 3 is the effective active flag (1 = active) and bits 2:0 are the effective boost.
- R8: When bit 0 of register 0x07 is 0, channel n is active when its enable pin is high. When that bit is 1, channel n is active when its disable flag is 0. The disable flags sit at bits 3 and 7 of registers 0x03 (channels 0, 1) and 0x04 (channels 2, 3).
- R9: With `pin_boost_force` high, every channel uses `pin_boost`. With it low, channel n uses the boost code in bits 2:0 of its nibble (lower channel in bits 3:0, upper channel in bits 7:4).
- R10: `thr_on_code` equals register 0x05 and `thr_off_code` equals register 0x06, with channel n in bits 2n+1:2n. `out_level` equals bits 3:2 of register 0x08.
- R11: A STOP, or `sel` going low, returns the protocol to idle from any state. A partial transaction that is cut off this way changes nothing, and a following transaction works normally.
- R12: The slave releases SDA within a quarter bit after the SCL falling edge that ends its ACK or data bit.
- R13: A pulse on a bus line that lasts fewer than `FILT_LEN` clock cycles is ignored. For example, a one-cycle low pulse on SDA while SCL is high creates no START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select; bus access only while high |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | Open-drain enable: 1 pulls SDA low |
| ch_detect | input | 4 | Live per-channel signal-detect flags |
| ch_pin_en | input | 4 | Per-channel enable pins |
| pin_boost | input | 3 | Shared boost code from pins |
| pin_boost_force | input | 1 | 1: pins set boost for all channels |
| ch_active | output | 4 | Effective per-channel active flag |
| ch_boost | output | 12 | Effective boost, channel n in bits 3n+2:3n |
| thr_on_code | output | 8 | ON-threshold codes, 2 bits per channel |
| thr_off_code | output | 8 | OFF-threshold codes, 2 bits per channel |
| out_level | output | 2 | Output-level code |

## Verification
The bench sends writes with the correct address, with an address that differs in its last bit, and with one that differs in its first bit. The ACK slot alone shows whether the address compare is complete.

Read-backs use data with mixed high and low bits, such as 0xA5, 0x97 and 0x0E. These expose any bit-order or shift-phase mistake, and they separate a live status byte from stored configuration.

The same channel-pin pattern is applied under both enable-source settings and both boost-source settings. Because the pin values and register values disagree per channel, each selection is visible at the outputs.

Aborted transactions are tested three ways: one cut by a STOP mid-address, one cut by dropping select mid-transfer, and one data byte carrying a one-cycle SDA glitch while SCL is high. Together they separate protocol recovery from filtering.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;
   localparam int NCH     = 4;
   localparam int BOOST_W = 3;
   localparam int THR_W   = 2;
   localparam int NIB_W   = 4;

   localparam logic [7:0] RA_DETECT  = 8'h00;
   localparam logic [7:0] RA_STAT_LO = 8'h01;
   localparam logic [7:0] RA_STAT_HI = 8'h02;
   localparam logic [7:0] RA_CFG_LO  = 8'h03;
   localparam logic [7:0] RA_CFG_HI  = 8'h04;
   localparam logic [7:0] RA_THR_ON  = 8'h05;
   localparam logic [7:0] RA_THR_OFF = 8'h06;
   localparam logic [7:0] RA_MODE    = 8'h07;
   localparam logic [7:0] RA_LEVEL   = 8'h08;

   localparam logic [7:0] CFG_RST   = 8'h44;
   localparam logic [7:0] LEVEL_RST = 8'h78;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK_ADDR,
      ST_PTR,
      ST_ACK_PTR,
      ST_WDATA,
      ST_ACK_DATA,
      ST_RDATA,
      ST_RACK,
      ST_SKIP
   } bus_st_t;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
   parameter int   STAGES   = 2,
   parameter int   FILT_LEN = 3,
   parameter logic RST_VAL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   localparam int CW = (FILT_LEN < 2) ? 1 : $clog2(FILT_LEN + 1);

   initial begin : param_chk
      assert (STAGES >= 2) else $error("line_filter: STAGES must be at least 2");
      assert (FILT_LEN >= 0) else $error("line_filter: FILT_LEN must not be negative");
   end

   logic [STAGES-1:0] sync_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sync_q <= {STAGES{RST_VAL}};
      else        sync_q <= {sync_q[STAGES-2:0], d_in};
   end

   generate
      if (FILT_LEN == 0) begin : g_direct
         assign q_out = sync_q[STAGES-1];
      end else begin : g_count
         logic [CW-1:0] run_q;
         logic          lvl_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               run_q <= '0;
               lvl_q <= RST_VAL;
            end else if (sync_q[STAGES-1] == lvl_q) begin
               run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
               run_q <= '0;
               lvl_q <= sync_q[STAGES-1];
            end else begin
               run_q <= run_q + 1'b1;
            end
         end

         assign q_out = lvl_q;

         // the filtered level only moves to a value the synchronizer already showed
         p_filter_agree_r13: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(lvl_q) |-> (lvl_q == $past(sync_q[STAGES-1])));
      end
   endgenerate
endmodule

// File: rtl/bus_engine.sv
module bus_engine
   import cfgbus_pkg::*;
#(
   parameter logic [6:0] SLV_ADDR = 7'b1010110
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       scl,
   input  logic       sda,
   output logic       pull,
   output logic       wr_en,
   output logic [7:0] wr_data,
   output logic [7:0] ptr,
   input  logic [7:0] rd_data
);
   localparam int BIT_CW = 4;
   localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(8);

   bus_st_t            st_q;
   logic               scl_p, sda_p;
   logic [7:0]         sh_q, tx_q;
   logic [BIT_CW-1:0]  cnt_q;
   logic               rw_q;
   logic               start_ev, stop_ev, rise, fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl;
         sda_p <= sda;
      end
   end

   assign start_ev = sel & scl & scl_p &  sda_p & ~sda;
   assign stop_ev  = sel & scl & scl_p & ~sda_p &  sda;
   assign rise     = scl & ~scl_p;
   assign fall     = ~scl & scl_p;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         pull    <= 1'b0;
         cnt_q   <= '0;
         sh_q    <= '0;
         tx_q    <= '0;
         rw_q    <= 1'b0;
         ptr     <= '0;
         wr_en   <= 1'b0;
         wr_data <= '0;
      end else begin
         wr_en <= 1'b0;
         if (!sel || stop_ev) begin
            st_q  <= ST_IDLE;
            pull  <= 1'b0;
            cnt_q <= '0;
         end else if (start_ev) begin
            st_q  <= ST_ADDR;
            pull  <= 1'b0;
            cnt_q <= '0;
         end else begin
            unique case (st_q)
               ST_ADDR, ST_PTR, ST_WDATA: begin
                  if (rise) begin
                     sh_q  <= {sh_q[6:0], sda};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (fall && cnt_q == LAST_BIT) begin
                     cnt_q <= '0;
                     if (st_q == ST_ADDR) begin
                        if (sh_q[7:1] == SLV_ADDR) begin
                           rw_q <= sh_q[0];
                           pull <= 1'b1;
                           st_q <= ST_ACK_ADDR;
                        end else begin
                           st_q <= ST_SKIP;
                        end
                     end else if (st_q == ST_PTR) begin
                        ptr  <= sh_q;
                        pull <= 1'b1;
                        st_q <= ST_ACK_PTR;
                     end else begin
                        wr_en   <= 1'b1;
                        wr_data <= sh_q;
                        pull    <= 1'b1;
                        st_q    <= ST_ACK_DATA;
                     end
                  end
               end
               ST_ACK_ADDR: begin
                  if (fall) begin
                     if (rw_q) begin
                        tx_q  <= rd_data;
                        pull  <= ~rd_data[7];
                        cnt_q <= '0;
                        st_q  <= ST_RDATA;
                     end else begin
                        pull <= 1'b0;
                        st_q <= ST_PTR;
                     end
                  end
               end
               ST_ACK_PTR: begin
                  if (fall) begin
                     pull <= 1'b0;
                     st_q <= ST_WDATA;
                  end
               end
               ST_ACK_DATA: begin
                  if (fall) begin
                     pull <= 1'b0;
                     st_q <= ST_SKIP;
                  end
               end
               ST_RDATA: begin
                  if (rise) begin
                     cnt_q <= cnt_q + 1'b1;
                  end else if (fall) begin
                     if (cnt_q == LAST_BIT) begin
                        pull  <= 1'b0;
                        cnt_q <= '0;
                        st_q  <= ST_RACK;
                     end else begin
                        tx_q <= {tx_q[6:0], 1'b0};
                        pull <= ~tx_q[6];
                     end
                  end
               end
               ST_RACK: begin
                  if (rise) st_q <= ST_SKIP;
               end
               default: ;
            endcase
         end
      end
   end

   p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stop_ev |=> (st_q == ST_IDLE) && !pull);

   p_ack_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !start_ev && !stop_ev && fall && (st_q == ST_ACK_PTR || st_q == ST_ACK_DATA)) |=> !pull);

   p_no_ack_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !start_ev && !stop_ev && st_q == ST_ADDR && fall && cnt_q == LAST_BIT
       && sh_q[7:1] != SLV_ADDR) |=> !pull);

   p_write_from_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ($past(st_q) == ST_WDATA) && (st_q == ST_ACK_DATA) && pull);
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
   import cfgbus_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [7:0]              addr,
   input  logic [7:0]              wr_data,
   output logic [7:0]              rd_data,
   input  logic [NCH-1:0]          ch_detect,
   input  logic [NCH-1:0]          ch_pin_en,
   input  logic [BOOST_W-1:0]      pin_boost,
   input  logic                    pin_boost_force,
   output logic [NCH-1:0]          ch_active,
   output logic [NCH*BOOST_W-1:0]  ch_boost,
   output logic [NCH*THR_W-1:0]    thr_on_code,
   output logic [NCH*THR_W-1:0]    thr_off_code,
   output logic [1:0]              out_level
);
   localparam int PK_W = NCH * NIB_W;

   initial begin : param_chk
      assert (PK_W == 16) else $error("cfg_regs: map packs exactly four channels");
      assert (NIB_W == BOOST_W + 1) else $error("cfg_regs: nibble is flag plus boost");
   end

   logic [PK_W-1:0]       cfg_pk;
   logic [PK_W-1:0]       stat_pk;
   logic [NCH*THR_W-1:0]  thr_on_q, thr_off_q;
   logic                  mode_q;
   logic [7:0]            level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_pk    <= {CFG_RST, CFG_RST};
         thr_on_q  <= '0;
         thr_off_q <= '0;
         mode_q    <= 1'b0;
         level_q   <= LEVEL_RST;
      end else if (wr_en) begin
         case (addr)
            RA_CFG_LO:  cfg_pk[7:0]  <= wr_data;
            RA_CFG_HI:  cfg_pk[15:8] <= wr_data;
            RA_THR_ON:  thr_on_q     <= wr_data;
            RA_THR_OFF: thr_off_q    <= wr_data;
            RA_MODE:    mode_q       <= wr_data[0];
            RA_LEVEL:   level_q      <= wr_data;
            default: ;
         endcase
      end
   end

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_ch
         logic [NIB_W-1:0]   nib;
         logic [BOOST_W-1:0] eff_boost;
         assign nib          = cfg_pk[g*NIB_W +: NIB_W];
         assign ch_active[g] = mode_q ? ~nib[NIB_W-1] : ch_pin_en[g];
         assign eff_boost    = pin_boost_force ? pin_boost : nib[BOOST_W-1:0];
         assign ch_boost[g*BOOST_W +: BOOST_W] = eff_boost;
         assign stat_pk[g*NIB_W +: NIB_W]      = {ch_active[g], eff_boost};
      end
   endgenerate

   always_comb begin
      case (addr)
         RA_DETECT:  rd_data = {{(8-NCH){1'b0}}, ch_detect};
         RA_STAT_LO: rd_data = stat_pk[7:0];
         RA_STAT_HI: rd_data = stat_pk[15:8];
         RA_CFG_LO:  rd_data = cfg_pk[7:0];
         RA_CFG_HI:  rd_data = cfg_pk[15:8];
         RA_THR_ON:  rd_data = thr_on_q;
         RA_THR_OFF: rd_data = thr_off_q;
         RA_MODE:    rd_data = {7'b0, mode_q};
         RA_LEVEL:   rd_data = level_q;
         default:    rd_data = 8'h00;
      endcase
   end

   assign thr_on_code  = thr_on_q;
   assign thr_off_code = thr_off_q;
   assign out_level    = level_q[3:2];

   p_ro_discard_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (addr < RA_CFG_LO || addr > RA_LEVEL))
      |=> $stable({cfg_pk, thr_on_q, thr_off_q, mode_q, level_q}));

   p_level_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == RA_LEVEL) |=> (out_level == $past(wr_data[3:2])));
endmodule

// File: rtl/cfg_twowire_regbank.sv
module cfg_twowire_regbank
   import cfgbus_pkg::*;
#(
   parameter logic [6:0] SLV_ADDR    = 7'b1010110,
   parameter int         SYNC_STAGES = 2,
   parameter int         FILT_LEN    = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sel,
   input  logic                    scl_in,
   input  logic                    sda_in,
   output logic                    sda_pull,
   input  logic [NCH-1:0]          ch_detect,
   input  logic [NCH-1:0]          ch_pin_en,
   input  logic [BOOST_W-1:0]      pin_boost,
   input  logic                    pin_boost_force,
   output logic [NCH-1:0]          ch_active,
   output logic [NCH*BOOST_W-1:0]  ch_boost,
   output logic [NCH*THR_W-1:0]    thr_on_code,
   output logic [NCH*THR_W-1:0]    thr_off_code,
   output logic [1:0]              out_level
);
   localparam int NLINES = 2;

   logic [NLINES-1:0] raw_lines, clean_lines;
   logic              pull_int, wr_en;
   logic [7:0]        wr_data, ptr, rd_data;

   assign raw_lines = {scl_in, sda_in};

   generate
      for (genvar li = 0; li < NLINES; li++) begin : g_line
         line_filter #(
            .STAGES  (SYNC_STAGES),
            .FILT_LEN(FILT_LEN),
            .RST_VAL (1'b1)
         ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .d_in (raw_lines[li]),
            .q_out(clean_lines[li])
         );
      end
   endgenerate

   bus_engine #(.SLV_ADDR(SLV_ADDR)) u_engine (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel),
      .scl    (clean_lines[1]),
      .sda    (clean_lines[0]),
      .pull   (pull_int),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .ptr    (ptr),
      .rd_data(rd_data)
   );

   cfg_regs u_regs (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en          (wr_en),
      .addr           (ptr),
      .wr_data        (wr_data),
      .rd_data        (rd_data),
      .ch_detect      (ch_detect),
      .ch_pin_en      (ch_pin_en),
      .pin_boost      (pin_boost),
      .pin_boost_force(pin_boost_force),
      .ch_active      (ch_active),
      .ch_boost       (ch_boost),
      .thr_on_code    (thr_on_code),
      .thr_off_code   (thr_off_code),
      .out_level      (out_level)
   );

   assign sda_pull = pull_int & sel;

   p_quiet_unsel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> !pull_int);
endmodule

// File: tb/test_cfg_twowire_regbank.sv
module test_cfg_twowire_regbank;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 12;
   localparam logic [6:0] DEV = 7'h56;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b1;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_pull;
   logic        sda_line;
   logic [3:0]  ch_detect = 4'h0;
   logic [3:0]  ch_pin_en = 4'hF;
   logic [2:0]  pin_boost = 3'b100;
   logic        pin_boost_force = 1'b1;
   logic [3:0]  ch_active;
   logic [11:0] ch_boost;
   logic [7:0]  thr_on_code, thr_off_code;
   logic [1:0]  out_level;

   int   n_chk = 0;
   int   n_fail = 0;
   int   unsel_drive = 0;
   logic last_rel;
   logic done = 1'b0;

   assign sda_line = sda_m & ~sda_pull;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_twowire_regbank i_cfg_twowire_regbank (
      .clk(clk), .rst_n(rst_n), .sel(sel), .scl_in(scl_m), .sda_in(sda_line),
      .sda_pull(sda_pull), .ch_detect(ch_detect), .ch_pin_en(ch_pin_en),
      .pin_boost(pin_boost), .pin_boost_force(pin_boost_force),
      .ch_active(ch_active), .ch_boost(ch_boost), .thr_on_code(thr_on_code),
      .thr_off_code(thr_off_code), .out_level(out_level)
   );

   always @(negedge clk) if (rst_n && !sel && sda_pull) unsel_drive++;

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m = 1'b0; wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m = 1'b1; wait_q();
   endtask

   task automatic send_byte(input logic [7:0] b, input logic glitch, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wait_q();
         scl_m = 1'b1; wait_q();
         if (glitch && i == 3) begin
            sda_m = 1'b0; @(negedge clk); sda_m = 1'b1;
         end
         wait_q();
         scl_m = 1'b0; wait_q();
      end
      sda_m = 1'b1; wait_q();
      scl_m = 1'b1; wait_q();
      ack = ~sda_line;
      wait_q();
      scl_m = 1'b0; wait_q();
      last_rel = sda_line;
   endtask

   task automatic recv_byte(output logic [7:0] d);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; wait_q();
         scl_m = 1'b1; wait_q();
         d[i] = sda_line;
         wait_q();
         scl_m = 1'b0; wait_q();
      end
      sda_m = 1'b1; wait_q();
      scl_m = 1'b1; wait_q(); wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   task automatic do_write(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d, output logic ok);
      logic a1, a2, a3;
      bus_start();
      send_byte({a, 1'b0}, 1'b0, a1);
      send_byte(p, 1'b0, a2);
      send_byte(d, 1'b0, a3);
      bus_stop();
      ok = a1 & a2 & a3;
   endtask

   task automatic do_read(input logic [7:0] p, output logic [7:0] d, output logic ok);
      logic a1, a2, a3;
      bus_start();
      send_byte({DEV, 1'b0}, 1'b0, a1);
      send_byte(p, 1'b0, a2);
      bus_start();
      send_byte({DEV, 1'b1}, 1'b0, a3);
      recv_byte(d);
      bus_stop();
      ok = a1 & a2 & a3;
   endtask

   task automatic expect_reg(input logic [7:0] p, input logic [7:0] exp, input string tag);
      logic [7:0] d;
      logic ok;
      do_read(p, d, ok);
      check(ok, {tag, " read acks"}, {31'b0, ok}, 32'h1);
      check(d == exp, tag, {24'b0, d}, {24'b0, exp});
   endtask

   task automatic t_reset();
      check(out_level == 2'b10, "R10 reset out_level", {30'b0, out_level}, 32'h2);
      check(thr_on_code == 8'h00, "R10 reset thr_on", {24'b0, thr_on_code}, 32'h0);
      expect_reg(8'h03, 8'h44, "R5 reg03 default");
      expect_reg(8'h04, 8'h44, "R5 reg04 default");
      expect_reg(8'h05, 8'h00, "R5 reg05 default");
      expect_reg(8'h06, 8'h00, "R5 reg06 default");
      expect_reg(8'h07, 8'h00, "R5 reg07 default");
      expect_reg(8'h08, 8'h78, "R5 reg08 default");
   endtask

   task automatic t_write_read();
      logic ok;
      do_write(DEV, 8'h05, 8'hA5, ok);
      check(ok, "R3 write acks", {31'b0, ok}, 32'h1);
      check(last_rel == 1'b1, "R12 SDA released after data ACK", {31'b0, last_rel}, 32'h1);
      check(thr_on_code == 8'hA5, "R10 thr_on follows reg05", {24'b0, thr_on_code}, 32'hA5);
      expect_reg(8'h05, 8'hA5, "R4 read back reg05");
      do_write(DEV, 8'h06, 8'h5A, ok);
      check(thr_off_code == 8'h5A, "R10 thr_off follows reg06", {24'b0, thr_off_code}, 32'h5A);
      do_write(DEV, 8'h08, 8'h3C, ok);
      check(out_level == 2'b11, "R10 out_level from reg08", {30'b0, out_level}, 32'h3);
      expect_reg(8'h08, 8'h3C, "R4 read back reg08");
   endtask

   task automatic t_addr();
      logic ok;
      do_write(7'h57, 8'h05, 8'h22, ok);
      check(!ok, "R1 last-bit-wrong address not acked", {31'b0, ok}, 32'h0);
      do_write(7'h16, 8'h05, 8'h33, ok);
      check(!ok, "R1 first-bit-wrong address not acked", {31'b0, ok}, 32'h0);
      expect_reg(8'h05, 8'hA5, "R1 foreign writes ignored");
   endtask

   task automatic t_csel();
      logic ok;
      sel = 1'b0;
      do_write(DEV, 8'h05, 8'h11, ok);
      check(!ok, "R2 no ACK while deselected", {31'b0, ok}, 32'h0);
      sel = 1'b1;
      wait_q();
      check(unsel_drive == 0, "R2 no SDA drive while deselected", unsel_drive, 32'h0);
      expect_reg(8'h05, 8'hA5, "R2 register untouched while deselected");
   endtask

   task automatic t_readonly();
      logic ok;
      do_write(DEV, 8'h01, 8'hFF, ok);
      check(ok, "R6 read-only write acked", {31'b0, ok}, 32'h1);
      expect_reg(8'h01, 8'hCC, "R6 read-only write discarded");
      do_write(DEV, 8'h20, 8'h12, ok);
      check(ok, "R6 unmapped write acked", {31'b0, ok}, 32'h1);
      expect_reg(8'h20, 8'h00, "R6 unmapped read is zero");
   endtask

   task automatic t_status();
      logic ok;
      ch_detect = 4'b1010;
      ch_pin_en = 4'b1001;
      pin_boost = 3'b011;
      wait_q();
      expect_reg(8'h00, 8'h0A, "R7 detect flags");
      expect_reg(8'h01, 8'h3B, "R7 status ch0/ch1 pin mode");
      expect_reg(8'h02, 8'hB3, "R7 status ch2/ch3 pin mode");
      check(ch_active == 4'b1001, "R8 active follows pins", {28'b0, ch_active}, 32'h9);
      check(ch_boost == 12'h6DB, "R9 forced pin boost", {20'b0, ch_boost}, 32'h6DB);
      do_write(DEV, 8'h03, 8'h1F, ok);
      do_write(DEV, 8'h04, 8'h86, ok);
      pin_boost_force = 1'b0;
      wait_q();
      check(ch_boost == 12'h18F, "R9 register boost per channel", {20'b0, ch_boost}, 32'h18F);
      check(ch_active == 4'b1001, "R8 pins still rule with mode 0", {28'b0, ch_active}, 32'h9);
      do_write(DEV, 8'h07, 8'h01, ok);
      check(ch_active == 4'b0110, "R8 active from disable flags", {28'b0, ch_active}, 32'h6);
      expect_reg(8'h01, 8'h97, "R7 status ch0/ch1 register mode");
      expect_reg(8'h02, 8'h0E, "R7 status ch2/ch3 register mode");
      expect_reg(8'h07, 8'h01, "R4 read back reg07");
   endtask

   task automatic t_abort();
      logic ok, a1, a2, a3;
      bus_start();
      for (int i = 0; i < 4; i++) begin
         sda_m = i[0]; wait_q();
         scl_m = 1'b1; wait_q(); wait_q();
         scl_m = 1'b0; wait_q();
      end
      bus_stop();
      do_write(DEV, 8'h06, 8'h33, ok);
      check(ok, "R11 write after STOP abort acked", {31'b0, ok}, 32'h1);
      check(thr_off_code == 8'h33, "R11 write after STOP abort lands", {24'b0, thr_off_code}, 32'h33);
      bus_start();
      send_byte({DEV, 1'b0}, 1'b0, a1);
      send_byte(8'h05, 1'b0, a2);
      sel = 1'b0;
      wait_q(); wait_q();
      sel = 1'b1;
      send_byte(8'hEE, 1'b0, a3);
      bus_stop();
      check(a1 && a2 && !a3, "R11 select drop aborts transfer", {29'b0, a1, a2, a3}, 32'h6);
      expect_reg(8'h05, 8'hA5, "R11 aborted data discarded");
   endtask

   task automatic t_glitch();
      logic a1, a2, a3;
      bus_start();
      send_byte({DEV, 1'b0}, 1'b0, a1);
      send_byte(8'h05, 1'b0, a2);
      send_byte(8'h69, 1'b1, a3);
      bus_stop();
      check(a1 && a2 && a3, "R13 glitched write still acked", {29'b0, a1, a2, a3}, 32'h7);
      expect_reg(8'h05, 8'h69, "R13 glitch ignored");
   endtask

   initial begin
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write_read();
      t_addr();
      t_csel();
      t_readonly();
      t_status();
      t_abort();
      t_glitch();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog all-requirements actual=timeout expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule